// File: doc/BRIEF.md
# Quadrature Bang-Bang Phase Detector

This block is the digital decision core of a clock-data recovery loop. It watches a serial stream that is oversampled on a common clock. An internal unit-interval counter stands in for the recovered clock. Four taps of that counter play the part of the in-phase and quadrature clock edges. The in-phase rising tap lies at the bit centre, the in-phase falling tap at the nominal transition point, and the two quadrature taps a quarter of a unit interval on either side of it.

At every bit boundary the block emits the retimed bit. It then compares the previous and the current centre samples with the edge sample. From that comparison it decides whether the data transition came early (lead, pump up) or late (lag, pump down). A weak strobe marks an ordinary correction. A strong strobe is added when a quadrature sample shows that the transition landed more than a quarter unit interval from its nominal point.

A mode input selects frequency acquisition. In that mode only the single weak level is produced. The charge pump and the oscillator that consume these strobes lie outside this block.

Top module: `qpd_top`

## Requirements
- R1: The unit-interval counter runs from 0 to OSR-1 and starts at 0 on the third rising clock edge after rst_n is released. On every edge where the counter is 0, rt_data takes ser_in and rt_valid is high for exactly the following cycle; rt_valid pulses are OSR cycles apart.
- R2: If the two consecutive centre samples differ and the edge sample (counter OSR/2) equals the new bit, up_weak is high in the rt_valid cycle.
- R3: If the two consecutive centre samples differ and the edge sample equals the old bit, dn_weak is high in the rt_valid cycle.
- R4: In tracking mode, if R2 applies and the early quadrature sample (counter OSR/4) also equals the new bit, up_strong is high together with up_weak.
- R5: In tracking mode, if R3 applies and the late quadrature sample (counter 3*OSR/4) still equals the old bit, dn_strong is high together with dn_weak.
- R6: When the consecutive centre samples are equal, and in the first rt_valid cycle after reset, all four strobes stay low.
- R7: up_weak and dn_weak are never high together, and each strong strobe is only high while its weak strobe is high.
- R8: When acq_mode is 1 at the decision edge, up_strong and dn_strong are low while the weak strobes follow R2 and R3 unchanged.
- R9: While rst_n is low, and until the first counter-0 edge, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OSR cycles per unit interval |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Oversampled serial data |
| acq_mode | input | 1 | 1 = frequency acquisition (single level), 0 = phase tracking |
| rt_data | output | 1 | Retimed data bit |
| rt_valid | output | 1 | One-cycle pulse at each bit boundary |
| up_weak | output | 1 | Ordinary pump-up correction |
| dn_weak | output | 1 | Ordinary pump-down correction |
| up_strong | output | 1 | Additional pump-up for an early transition beyond a quarter UI |
| dn_strong | output | 1 | Additional pump-down for a late transition beyond a quarter UI |

## Verification
The bench builds the block with OSR = 8. The quadrature taps then sit at counter values 2 and 6 and the edge tap at 4. Transition offsets 1 to 7 therefore land on both sides of every tap, including offsets that coincide exactly with a tap. Alternating, run-length and random bit patterns, with an acquisition-mode stretch in the middle, exercise every strobe combination and the suppression cases.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

  // Samples captured across one unit interval, by tap.
  typedef struct packed {
    logic ctr;   // in-phase rising tap: bit centre
    logic qe;    // quadrature rising tap: quarter UI before the edge
    logic edg;   // in-phase falling tap: nominal transition
    logic ql;    // quadrature falling tap: quarter UI after the edge
  } qpd_taps_t;

  typedef struct packed {
    logic up_w;
    logic dn_w;
    logic up_s;
    logic dn_s;
  } qpd_corr_t;

  localparam int unsigned NUM_TAPS = 4;

endpackage

// File: rtl/qpd_rst_sync.sv
module qpd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;

endmodule

// File: rtl/qpd_phase_gen.sv
module qpd_phase_gen #(
  parameter int unsigned OSR = 8,
  localparam int unsigned PW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          srst_n,
  output logic [PW-1:0] ph,
  output logic          ui_start
);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_nxt;
  logic          ph_wrap;
  logic          ph_en;

  assign ph_en   = 1'b1;
  assign ph_wrap = (ph_q == PW'(OSR - 1));

  always_comb begin
    ph_nxt = ph_q;
    if (ph_en) begin
      ph_nxt = ph_wrap ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_nxt;
    end
  end

  assign ph       = ph_q;
  assign ui_start = (ph_q == '0);

endmodule

// File: rtl/qpd_sampler.sv
module qpd_sampler
  import qpd_pkg::*;
#(
  parameter int unsigned OSR = 8,
  localparam int unsigned PW  = $clog2(OSR),
  localparam int unsigned QTR = OSR / 4
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [PW-1:0] ph,
  input  logic          ser_in,
  output qpd_taps_t     taps
);

  logic [NUM_TAPS-1:0] tap_q;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned TAP_PH = g * QTR;
    logic hit;
    logic tap_nxt;

    assign hit = (ph == TAP_PH[PW-1:0]);

    always_comb begin
      tap_nxt = tap_q[g];
      if (hit) begin
        tap_nxt = ser_in;
      end
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        tap_q[g] <= 1'b0;
      end else begin
        tap_q[g] <= tap_nxt;
      end
    end
  end

  assign taps.ctr = tap_q[0];
  assign taps.qe  = tap_q[1];
  assign taps.edg = tap_q[2];
  assign taps.ql  = tap_q[3];

endmodule

// File: rtl/qpd_decide.sv
module qpd_decide
  import qpd_pkg::*;
(
  input  logic      clk,
  input  logic      srst_n,
  input  logic      ui_start,
  input  logic      ser_in,
  input  logic      acq_mode,
  input  qpd_taps_t taps,
  output logic      rt_data,
  output logic      rt_valid,
  output qpd_corr_t corr
);

  logic      primed_q, primed_nxt;
  logic      rt_q, rt_nxt;
  logic      vld_q, vld_nxt;
  qpd_corr_t corr_q, corr_nxt;

  logic old_bit, new_bit, trans, lead, lag;

  assign old_bit = taps.ctr;
  assign new_bit = ser_in;
  assign trans   = primed_q & (old_bit ^ new_bit);
  assign lead    = trans & (taps.edg == new_bit);
  assign lag     = trans & (taps.edg == old_bit);

  always_comb begin
    primed_nxt = primed_q;
    rt_nxt     = rt_q;
    vld_nxt    = 1'b0;
    corr_nxt   = '0;
    if (ui_start) begin
      primed_nxt    = 1'b1;
      rt_nxt        = new_bit;
      vld_nxt       = 1'b1;
      corr_nxt.up_w = lead;
      corr_nxt.dn_w = lag;
      corr_nxt.up_s = lead & (taps.qe == new_bit) & ~acq_mode;
      corr_nxt.dn_s = lag  & (taps.ql == old_bit) & ~acq_mode;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      primed_q <= 1'b0;
      rt_q     <= 1'b0;
      vld_q    <= 1'b0;
      corr_q   <= '0;
    end else begin
      primed_q <= primed_nxt;
      rt_q     <= rt_nxt;
      vld_q    <= vld_nxt;
      corr_q   <= corr_nxt;
    end
  end

  assign rt_data  = rt_q;
  assign rt_valid = vld_q;
  assign corr     = corr_q;

endmodule

// File: rtl/qpd_top.sv
module qpd_top
  import qpd_pkg::*;
#(
  parameter int unsigned OSR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic acq_mode,
  output logic rt_data,
  output logic rt_valid,
  output logic up_weak,
  output logic dn_weak,
  output logic up_strong,
  output logic dn_strong
);

  localparam int unsigned PW = $clog2(OSR);

  logic          srst_n;
  logic [PW-1:0] ph;
  logic          ui_start;
  qpd_taps_t     taps;
  qpd_corr_t     corr;

  qpd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  qpd_phase_gen #(.OSR(OSR)) u_ph (
    .clk      (clk),
    .srst_n   (srst_n),
    .ph       (ph),
    .ui_start (ui_start)
  );

  qpd_sampler #(.OSR(OSR)) u_smp (
    .clk    (clk),
    .srst_n (srst_n),
    .ph     (ph),
    .ser_in (ser_in),
    .taps   (taps)
  );

  qpd_decide u_dec (
    .clk      (clk),
    .srst_n   (srst_n),
    .ui_start (ui_start),
    .ser_in   (ser_in),
    .acq_mode (acq_mode),
    .taps     (taps),
    .rt_data  (rt_data),
    .rt_valid (rt_valid),
    .corr     (corr)
  );

  assign up_weak   = corr.up_w;
  assign dn_weak   = corr.dn_w;
  assign up_strong = corr.up_s;
  assign dn_strong = corr.dn_s;

endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
  parameter int unsigned OSR = 8
) (
  input logic clk,
  input logic rst_n,
  input logic acq_mode,
  input logic rt_data,
  input logic rt_valid,
  input logic up_weak,
  input logic dn_weak,
  input logic up_strong,
  input logic dn_strong
);

  logic        seen_q;
  logic        last_q;
  int unsigned gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
      gap_q  <= 0;
    end else begin
      if (rt_valid) begin
        seen_q <= 1'b1;
        last_q <= rt_data;
        gap_q  <= 0;
      end else begin
        gap_q  <= gap_q + 1;
      end
    end
  end

  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && seen_q) |-> (gap_q == OSR - 1));                       // R1

  AST_STROBE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (up_weak || dn_weak) |-> rt_valid);                                 // R2

  AST_STROBE_NEEDS_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_weak || dn_weak) |-> (seen_q && (rt_data != last_q)));           // R6

  AST_TRANS_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && seen_q && (rt_data != last_q)) |-> (up_weak || dn_weak)); // R3

  AST_WEAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_weak, dn_weak}));                                      // R7

  AST_UP_STRONG_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
    up_strong |-> up_weak);                                             // R4

  AST_DN_STRONG_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
    dn_strong |-> dn_weak);                                             // R5

  AST_ACQ_NO_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && $past(acq_mode)) |-> !(up_strong || dn_strong));        // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(rt_valid || up_weak || dn_weak || up_strong || dn_strong)); // R9

endmodule

bind qpd_top qpd_checker #(.OSR(OSR)) u_qpd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acq_mode  (acq_mode),
  .rt_data   (rt_data),
  .rt_valid  (rt_valid),
  .up_weak   (up_weak),
  .dn_weak   (dn_weak),
  .up_strong (up_strong),
  .dn_strong (dn_strong)
);

// File: tb/qpd_top_bench.sv
`timescale 1ns/1ps
module qpd_top_bench;

  localparam int OSR = 8;
  localparam int NB  = 400;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_in;
  logic acq_mode;
  logic rt_data, rt_valid, up_weak, dn_weak, up_strong, dn_strong;

  int n_cmp = 0;
  int n_bad = 0;

  bit bits[$];
  int offs[$];
  bit acqs[$];

  always #5 clk = ~clk;

  qpd_top #(.OSR(OSR)) u_qpd_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .acq_mode  (acq_mode),
    .rt_data   (rt_data),
    .rt_valid  (rt_valid),
    .up_weak   (up_weak),
    .dn_weak   (dn_weak),
    .up_strong (up_strong),
    .dn_strong (dn_strong)
  );

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, nm, $time, act, exp);
    end
  endtask

  // Compare all outputs against an expected set; tag picks the requirement.
  task automatic check_all(input string tr, input logic e_rt, input logic e_v,
                           input logic e_uw, input logic e_dw,
                           input logic e_us, input logic e_ds, input string tg);
    string t_uw, t_dw, t_us, t_ds;
    t_uw = (tg == "") ? "R2" : tg;
    t_dw = (tg == "") ? "R3" : tg;
    t_us = (tg == "") ? "R4" : tg;
    t_ds = (tg == "") ? "R5" : tg;
    cmp(tr, "rt_data", rt_data, e_rt);
    cmp(tr, "rt_valid", rt_valid, e_v);
    cmp(t_uw, "up_weak", up_weak, e_uw);
    cmp(t_dw, "dn_weak", dn_weak, e_dw);
    cmp(t_us, "up_strong", up_strong, e_us);
    cmp(t_ds, "dn_strong", dn_strong, e_ds);
    // R7: exclusivity and strong-implies-weak seen at the ports
    cmp("R7", "weak_excl", up_weak & dn_weak, 1'b0);
    cmp("R7", "strong_no_weak", (up_strong & ~up_weak) | (dn_strong & ~dn_weak), 1'b0);
  endtask

  function automatic logic wave(input int t);
    int k, j;
    k = t / OSR;
    j = t % OSR;
    return (j < offs[k]) ? bits[k] : bits[k + 1];
  endfunction

  initial begin
    int seed;
    seed = 13;
    void'($urandom(seed));
    for (int k = 0; k <= NB; k++) begin
      bit b;
      int o;
      if (k < 64)       begin b = k[0];               o = 1 + (k % (OSR - 1)); end
      else if (k < 128) begin b = ((k / 5) % 2) == 1; o = 1 + ($urandom % (OSR - 1)); end
      else              begin b = $urandom % 2;       o = 1 + ($urandom % (OSR - 1)); end
      bits.push_back(b);
      offs.push_back(o);
      acqs.push_back(k >= 200 && k < 300);
    end
  end

  initial begin
    logic hold_rt;
    rst_n    = 1'b0;
    ser_in   = 1'b0;
    acq_mode = 1'b0;
    repeat (4) begin
      @(posedge clk);
      @(negedge clk);
      check_all("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    end
    rst_n  = 1'b1;
    ser_in = wave(0);
    // two synchronizer edges, outputs still quiet
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      check_all("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    end
    hold_rt = 1'b0;
    for (int t = 0; t < NB * OSR; t++) begin
      int k;
      k = t / OSR;
      ser_in   = wave(t);
      acq_mode = acqs[k];
      @(posedge clk);
      @(negedge clk);
      if (t % OSR == 0) begin
        logic uw, dw, us, ds;
        string tg;
        uw = 1'b0; dw = 1'b0; us = 1'b0; ds = 1'b0;
        tg = "";
        hold_rt = bits[k];
        if (k == 0 || bits[k - 1] == bits[k]) begin
          tg = "R6";
        end else begin
          int p;
          p  = offs[k - 1];
          uw = (p <= OSR / 2);
          dw = !uw;
          if (acqs[k]) tg = "R8";
          else begin
            us = (p <= OSR / 4);
            ds = (p > 3 * OSR / 4);
          end
        end
        check_all("R1", hold_rt, 1'b1, uw, dw, us, ds, tg);
      end else begin
        check_all("R1", hold_rt, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule